// File: doc/BRIEF.md
# Selectable Core Clock Divider

This block produces the core-clock timing for an audio converter subsystem. Two input clocks can feed it: a direct master clock and the output of a PLL. Both are presented as per-cycle edge strobes in the block's own clock domain. A four-bit control register chooses the source, states the ratio of the direct input clock to the base sampling frequency (256, 512, 768 or 1024 times fS), and enables the output. The block divides the selected strobe train by an integer from 1 to 4, so the core rate always lands at 256 times fS.

The PLL output always runs at 1024 times fS. When the PLL is the source, the divide ratio is therefore forced to 4 and the rate field is ignored. For example, a 49.152 MHz PLL output divided by 4 gives a 12.288 MHz core rate, which is fS = 48 kHz. The output is a clock-enable pulse train, one pulse per core-clock period, together with a status of the divide ratio in force.

Changes to the source or the ratio are applied only at a period boundary, so the output never has a shortened period. While the enable is off, the counter is held at zero and no pulses leave the block.

Top module: `coreclk_div`

## Requirements
- R1: A synchronous reset clears the control register to 0000: direct source, rate code 00, disabled. After reset, `core_en_o` is 0 and `ratio_o` reads 1.
- R2: Control bit 0 is the enable. While it is 0, no pulse is issued and the counter is held at zero. After it is set, the first pulse follows the Nth selected tick, where N is the ratio.
- R3: With bit 3 = 0, control bits [2:1] give the ratio. Code 00 gives N=1, 01 gives N=2, 10 gives N=3 and 11 gives N=4. One pulse is issued per N ticks of the direct strobe, and with N=1 every tick produces a pulse.
- R4: With bit 3 = 1, the PLL strobe is counted and N is 4 regardless of bits [2:1].
- R5: Only the strobe of the selected source advances the counter. Ticks on the other input have no effect on the pulses.
- R6: A written change of source or rate affects a period only at its start. A period already in progress completes with the ratio and source it began with.
- R7: `ratio_o` gives, as a 3-bit binary value from 1 to 4, the ratio of the current period. When the counter is idle at zero, it gives the ratio the register currently selects.
- R8: A write with `wr_en_i` = 1 stores `wr_data_i[3:0]` (bit 3 source, bits 2:1 rate, bit 0 enable). `rd_data_o` returns the stored value from the next cycle on.
- R9: `core_en_o` is registered. It is high for exactly the one cycle after the clock edge that sampled the Nth tick of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; both tick inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 4 | Control write data: [3] source, [2:1] rate code, [0] enable |
| rd_data_o | output | 4 | Current control register contents |
| dir_tick_i | input | 1 | One-cycle strobe per edge of the direct master clock |
| pll_tick_i | input | 1 | One-cycle strobe per edge of the PLL clock |
| core_en_o | output | 1 | Core clock-enable pulse, one per core period |
| ratio_o | output | 3 | Divide ratio in force, 1 to 4 |

## Verification
A write is visible on `rd_data_o` one cycle after the edge that takes it. A tick sampled at an edge yields its pulse on `core_en_o` in the cycle right after that same edge. `ratio_o` reflects the counter state left by the last edge. The bench drives every input at the falling edge and advances a reference model of the counting rules at the rising edge. It compares all three outputs at the following falling edge, so each result is checked in exactly the cycle it is due. Directed runs count the pulses over a fixed number of ticks for every ratio and for the PLL source, and they probe a mid-period ratio change.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int CTRL_W    = 4;
    localparam int MAX_RATIO = 4;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
    localparam int CNT_W     = $clog2(MAX_RATIO);

    // Control register layout: [3] source, [2:1] rate code, [0] enable
    typedef struct packed {
        logic       src_pll;
        logic [1:0] rate;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [RATIO_W-1:0] act_ratio;
        logic               act_src;
        logic               pulse;
    } cnt_state_t;

endpackage

// File: rtl/cdiv_ctrl_reg.sv
module cdiv_ctrl_reg
    import cdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output ctrl_t             ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i) begin
            ctrl_d = ctrl_t'(wr_data_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

    // R8: written value readable the next cycle
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (ctrl_q == ctrl_t'($past(wr_data_i))));

endmodule

// File: rtl/cdiv_ratio_dec.sv
module cdiv_ratio_dec
    import cdiv_pkg::*;
(
    input  ctrl_t              ctrl_i,
    output logic [RATIO_W-1:0] ratio_o
);

    // Rate code c selects a divide of c+1; the PLL source always divides by the maximum
    always_comb begin
        if (ctrl_i.src_pll) begin
            ratio_o = RATIO_W'(MAX_RATIO);
        end else begin
            ratio_o = RATIO_W'(ctrl_i.rate) + RATIO_W'(1);
        end
    end

endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter
    import cdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] req_ratio_i,
    input  logic               req_src_i,
    input  logic               dir_tick_i,
    input  logic               pll_tick_i,
    output logic               pulse_o,
    output logic [RATIO_W-1:0] ratio_o
);

    cnt_state_t st_d, st_q;

    logic               idle;
    logic [RATIO_W-1:0] eff_ratio;
    logic               eff_src;
    logic               tick;
    logic               hit;

    always_comb begin
        // A new configuration is accepted only while the counter sits at zero
        idle      = (st_q.cnt == '0);
        eff_ratio = idle ? req_ratio_i : st_q.act_ratio;
        eff_src   = idle ? req_src_i   : st_q.act_src;
        tick      = eff_src ? pll_tick_i : dir_tick_i;
        hit       = en_i && tick &&
                    (RATIO_W'(st_q.cnt) == (eff_ratio - RATIO_W'(1)));

        st_d       = st_q;
        st_d.pulse = hit;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (idle) begin
                st_d.act_ratio = eff_ratio;
                st_d.act_src   = eff_src;
            end
            st_d.cnt = hit ? '0 : (st_q.cnt + CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt       <= '0;
            st_q.act_ratio <= RATIO_W'(1);
            st_q.act_src   <= 1'b0;
            st_q.pulse     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign ratio_o = eff_ratio;

    // R2: disabled counter issues nothing in the following cycle
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !st_q.pulse);

    // R2: counter parked at zero while disabled
    p_held_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (st_q.cnt == '0));

    // R3: a running count stays below its period length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != '0) |-> (RATIO_W'(st_q.cnt) < st_q.act_ratio));

    // R4: a latched PLL period always divides by the maximum
    p_pll_forces_max_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.act_src |-> (st_q.act_ratio == RATIO_W'(MAX_RATIO)));

    // R6: configuration frozen inside a period
    p_frozen_mid_period_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != '0) |=> ($stable(st_q.act_ratio) && $stable(st_q.act_src)));

    // R9: a pulse always marks a wrap back to zero
    p_pulse_at_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> (st_q.cnt == '0));

endmodule

// File: rtl/coreclk_div.sv
module coreclk_div
    import cdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [CTRL_W-1:0]  wr_data_i,
    output logic [CTRL_W-1:0]  rd_data_o,
    input  logic               dir_tick_i,
    input  logic               pll_tick_i,
    output logic               core_en_o,
    output logic [RATIO_W-1:0] ratio_o
);

    ctrl_t              ctrl;
    logic [RATIO_W-1:0] req_ratio;

    cdiv_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl)
    );

    cdiv_ratio_dec u_dec (
        .ctrl_i  (ctrl),
        .ratio_o (req_ratio)
    );

    cdiv_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl.en),
        .req_ratio_i (req_ratio),
        .req_src_i   (ctrl.src_pll),
        .dir_tick_i  (dir_tick_i),
        .pll_tick_i  (pll_tick_i),
        .pulse_o     (core_en_o),
        .ratio_o     (ratio_o)
    );

    assign rd_data_o = CTRL_W'(ctrl);

    // R7: reported ratio always within 1..MAX_RATIO
    p_ratio_range_r7: assert property (@(posedge clk) disable iff (rst)
        (ratio_o >= RATIO_W'(1)) && (ratio_o <= RATIO_W'(MAX_RATIO)));

endmodule

// File: tb/tb_coreclk_div.sv
module tb_coreclk_div;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] rd_data;
    logic       dir_tick = 1'b0;
    logic       pll_tick = 1'b0;
    logic       core_en;
    logic [2:0] ratio;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_reg;
    int         m_cnt;
    int         m_act;
    bit         m_src;
    bit         m_pulse;
    int         pulse_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    coreclk_div dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .dir_tick_i (dir_tick),
        .pll_tick_i (pll_tick),
        .core_en_o  (core_en),
        .ratio_o    (ratio)
    );

    function automatic int reg_ratio(input logic [3:0] r);
        return r[3] ? 4 : (int'(r[2:1]) + 1);
    endfunction

    function automatic int eff_ratio();
        return (m_cnt == 0) ? reg_ratio(m_reg) : m_act;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit wr, input logic [3:0] d, input bit dt, input bit pt);
        int  er;
        bit  es;
        bit  tk;
        er = eff_ratio();
        es = (m_cnt == 0) ? m_reg[3] : m_src;
        tk = es ? pt : dt;
        m_pulse = m_reg[0] && tk && (m_cnt == er - 1);
        if (!m_reg[0]) begin
            m_cnt = 0;
        end else if (tk) begin
            if (m_cnt == 0) begin
                m_act = er;
                m_src = es;
            end
            m_cnt = m_pulse ? 0 : m_cnt + 1;
        end
        if (wr) m_reg = d;
    endtask

    // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(input bit wr, input logic [3:0] d, input bit dt, input bit pt);
        wr_en    = wr;
        wr_data  = d;
        dir_tick = dt;
        pll_tick = pt;
        @(posedge clk);
        model_edge(wr, d, dt, pt);
        @(negedge clk);
        check("R9 core_en_o", int'(core_en), int'(m_pulse));
        check("R8 rd_data_o", int'(rd_data), int'(m_reg));
        check("R7 ratio_o", int'(ratio), eff_ratio());
        if (core_en) pulse_count++;
    endtask

    task automatic run_count(input logic [3:0] cfg, input bit dt, input bit pt,
                             input int n, input string tag, input int exp_pulses);
        step(1'b1, 4'h0, 1'b0, 1'b0);
        step(1'b1, cfg, 1'b0, 1'b0);
        pulse_count = 0;
        for (int i = 0; i < n; i++) step(1'b0, 4'h0, dt, pt);
        check(tag, pulse_count, exp_pulses);
    endtask

    initial begin
        m_reg = 4'h0; m_cnt = 0; m_act = 1; m_src = 1'b0; m_pulse = 1'b0;
        pulse_count = 0;
        void'($urandom(32'h5eed_c10c));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rd_data_o", int'(rd_data), 0);
        check("R1 core_en_o", int'(core_en), 0);
        check("R1 ratio_o", int'(ratio), 1);

        // R2: disabled, ticks everywhere, no pulse
        pulse_count = 0;
        for (int i = 0; i < 16; i++) step(1'b0, 4'h0, 1'b1, 1'b1);
        check("R2 pulses while disabled", pulse_count, 0);

        // R3: every rate code on the direct source, 24 ticks
        run_count(4'b0_00_1, 1'b1, 1'b0, 24, "R3 divide-by-1 pulses", 24);
        run_count(4'b0_01_1, 1'b1, 1'b0, 24, "R3 divide-by-2 pulses", 12);
        run_count(4'b0_10_1, 1'b1, 1'b0, 24, "R3 divide-by-3 pulses", 8);
        run_count(4'b0_11_1, 1'b1, 1'b0, 24, "R3 divide-by-4 pulses", 6);

        // R2: first pulse right after the Nth tick following enable
        step(1'b1, 4'h0, 1'b0, 1'b0);
        step(1'b1, 4'b0_10_1, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R2 no pulse after tick 1", int'(core_en), 0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R2 no pulse after tick 2", int'(core_en), 0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R2 pulse after tick 3", int'(core_en), 1);

        // R4: PLL source forces divide-by-4 whatever the rate code
        run_count(4'b1_00_1, 1'b0, 1'b1, 24, "R4 pll rate 00 pulses", 6);
        run_count(4'b1_01_1, 1'b1, 1'b1, 24, "R4 pll rate 01 pulses", 6);
        check("R4 ratio_o under pll", int'(ratio), 4);

        // R5: ticks on the unselected input ignored
        run_count(4'b0_00_1, 1'b0, 1'b1, 20, "R5 pll ticks on direct source", 0);
        run_count(4'b1_00_1, 1'b1, 1'b0, 20, "R5 direct ticks on pll source", 0);

        // R6: mid-period change waits for the wrap
        step(1'b1, 4'h0, 1'b0, 1'b0);
        step(1'b1, 4'b0_11_1, 1'b0, 1'b0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        step(1'b1, 4'b0_00_1, 1'b1, 1'b0);
        check("R6 ratio held mid-period", int'(ratio), 4);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R6 no early pulse", int'(core_en), 0);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R6 old period completes", int'(core_en), 1);
        check("R6 new ratio after wrap", int'(ratio), 1);
        step(1'b0, 4'h0, 1'b1, 1'b0);
        check("R6 new ratio in force", int'(core_en), 1);

        // random phase, checked each cycle against the model
        for (int i = 0; i < 4000; i++) begin
            bit         w;
            logic [3:0] d;
            w = (($urandom() % 12) == 0);
            d = 4'($urandom());
            if (($urandom() % 3) != 0) d[0] = 1'b1;
            step(w, d, 1'($urandom()), 1'($urandom()));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule